// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller. It serves three banks of 30 pins each. Every pin has its own configuration bits: direction, pad ownership, output value, interrupt trigger kind, trigger level or edge sense, and interrupt mask. It also has a sticky interrupt flag and a readable synchronized input value. Software reaches all of this through a plain 32-bit register bus whose reads are combinational.

The register space is split into 16-byte groups, one group per kind of register. Inside a group the three banks sit at a 4-byte stride. Pad inputs pass through a two-flop synchronizer. The synchronized value feeds the input-data register and the trigger detectors. Each bank drives one interrupt line. The line is high while at least one of its pins is configured as an input, is unmasked and has its flag set.

The reset input is asserted asynchronously and released through a two-stage synchronizer. Every register is cleared by that synchronized reset.

Top module: `pinbank_gpio`

## Requirements
- R1: Address bits [7:4] pick the register group: 0x0 direction, 0x2 trigger sense, 0x3 trigger kind, 0x4 interrupt mask, 0x5 interrupt flags, 0x6 pad ownership, 0x7 input data, 0x8 output data. Bits [3:2] pick the bank (0 to 2). Bank 3, any other group, and any address with bits [1:0] nonzero read as zero and ignore writes.
- R2: Each register holds 30 bits. Read bits 31:30 are always zero.
- R3: While reset is asserted, all direction bits read 1 (input) and every other register reads 0. All interrupt lines are low and no pad is owned or driven.
- R4: For every pin, pad_own follows the ownership bit. pad_oe is 1 only when the pin is owned and its direction bit is 0 (output). pad_out carries the output-data bit.
- R5: A pad change appears in the input-data register after the second rising clock edge that follows it, and not after the first.
- R6: With trigger kind 1 (edge), a flag is set on the third rising edge after the pad moves to the sensed level. Sense 1 means a rising edge and 0 a falling edge. Moving away from that level sets nothing.
- R7: With trigger kind 0 (level), the flag is set on every cycle in which the synchronized input equals the sense bit (1 high, 0 low). A clearing write therefore does not take effect while the level persists.
- R8: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. A trigger in the same cycle as a clearing write wins.
- R9: A bank's interrupt line is high exactly when some pin has direction 1, mask 1 and flag 1.
- R10: The input-data register is read-only. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| pad_in | input | 90 | Raw pad levels, bank-major (bank b pin p at index 30b+p) |
| pad_out | output | 90 | Value to drive on each pad |
| pad_oe | output | 90 | Output enable per pad |
| pad_own | output | 90 | Pad claimed by the GPIO function |
| irq | output | 3 | One interrupt line per bank |

## Verification
A corrupted configuration bit shows up at once, either on pad_oe/pad_out or in the next read of the same group. The bench writes a distinct pattern to every bank and group, then reads the whole space back, so a mis-decoded bank or group cannot stay hidden. A fault in a trigger detector or in the flag update shows three edges after a pad change. The bench samples the flag both one cycle before and at that point, so early or late setting is caught as well as missing setting. It also watches the interrupt line of every bank, so masking faults and wrong bank routing are visible in the same cycle.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int NBANKS = 3;
  localparam int NPINS  = 30;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  typedef enum logic [3:0] {
    GRP_DIR  = 4'h0,
    GRP_SNS  = 4'h2,
    GRP_KIND = 4'h3,
    GRP_MASK = 4'h4,
    GRP_FLAG = 4'h5,
    GRP_OWN  = 4'h6,
    GRP_DIN  = 4'h7,
    GRP_DOUT = 4'h8
  } grp_e;
endpackage

// File: rtl/pinbank_rst_sync.sv
module pinbank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= raw_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
  import pinbank_pkg::*;
#(
  parameter int NPINS = pinbank_pkg::NPINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       grp,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] pin_sync,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_own,
  output logic             irq
);
  logic [NPINS-1:0] dir_q, sns_q, kind_q, mask_q, flag_q, own_q, dout_q, prev_q;
  logic [NPINS-1:0] dir_d, sns_d, kind_d, mask_d, flag_d, own_d, dout_d;
  logic [NPINS-1:0] at_level, edge_hit, trig;
  logic             cfg_en, flag_wr;

  // trigger detection on the synchronized input
  always_comb begin
    at_level = ~(pin_sync ^ sns_q);
    edge_hit = at_level & (prev_q ^ sns_q);
    trig     = (kind_q & edge_hit) | (~kind_q & at_level);
  end

  // next-state
  always_comb begin
    cfg_en  = wr_en;
    flag_wr = wr_en && (grp == GRP_FLAG);
    dir_d   = dir_q;
    sns_d   = sns_q;
    kind_d  = kind_q;
    mask_d  = mask_q;
    own_d   = own_q;
    dout_d  = dout_q;
    case (grp)
      GRP_DIR:  dir_d  = wdata;
      GRP_SNS:  sns_d  = wdata;
      GRP_KIND: kind_d = wdata;
      GRP_MASK: mask_d = wdata;
      GRP_OWN:  own_d  = wdata;
      GRP_DOUT: dout_d = wdata;
      default:  ;
    endcase
    flag_d = (flag_wr ? (flag_q & wdata) : flag_q) | trig;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      sns_q  <= '0;
      kind_q <= '0;
      mask_q <= '0;
      own_q  <= '0;
      dout_q <= '0;
    end else if (cfg_en) begin
      dir_q  <= dir_d;
      sns_q  <= sns_d;
      kind_q <= kind_d;
      mask_q <= mask_d;
      own_q  <= own_d;
      dout_q <= dout_d;
    end
  end

  // flags and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      prev_q <= '0;
    end else begin
      flag_q <= flag_d;
      prev_q <= pin_sync;
    end
  end

  always_comb begin
    case (grp)
      GRP_DIR:  rdata = dir_q;
      GRP_SNS:  rdata = sns_q;
      GRP_KIND: rdata = kind_q;
      GRP_MASK: rdata = mask_q;
      GRP_FLAG: rdata = flag_q;
      GRP_OWN:  rdata = own_q;
      GRP_DIN:  rdata = pin_sync;
      GRP_DOUT: rdata = dout_q;
      default:  rdata = '0;
    endcase
  end

  assign pad_own = own_q;
  assign pad_oe  = own_q & ~dir_q;
  assign pad_out = dout_q;
  assign irq     = |(dir_q & mask_q & flag_q);

  // R8: without a flag write, no set flag may drop
  a_r8_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_wr) |-> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R6: a newly set edge flag needs the input to have arrived at the sensed level
  a_r6_edge_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q) & $past(kind_q)) &
     ~($past(prev_q ^ sns_q) & ~$past(pin_sync ^ sns_q))) == '0);

  // R7: a newly set level flag needs the input to sit at the sensed level
  a_r7_level_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~$past(flag_q) & ~$past(kind_q) & $past(pin_sync ^ sns_q)) == '0);
endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
  import pinbank_pkg::*;
#(
  parameter int NBANKS = pinbank_pkg::NBANKS,
  parameter int NPINS  = pinbank_pkg::NPINS,
  parameter int DATA_W = pinbank_pkg::DATA_W,
  parameter int ADDR_W = pinbank_pkg::ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NBANKS*NPINS-1:0] pad_in,
  output logic [NBANKS*NPINS-1:0] pad_out,
  output logic [NBANKS*NPINS-1:0] pad_oe,
  output logic [NBANKS*NPINS-1:0] pad_own,
  output logic [NBANKS-1:0]       irq
);
  localparam int TOTAL = NBANKS * NPINS;

  logic             rst_sync_n;
  logic [TOTAL-1:0] pad_sync;
  logic [3:0]       grp;
  logic [1:0]       bsel;
  logic             addr_ok;
  logic [NPINS-1:0] rd_bank [NBANKS];
  logic             addr_unused;

  assign grp         = bus_addr[7:4];
  assign bsel        = bus_addr[3:2];
  assign addr_ok     = (bus_addr[1:0] == 2'b00);
  assign addr_unused = ^{bus_addr, bus_wdata};

  pinbank_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pinbank_sync #(.W(TOTAL)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .raw_i  (pad_in),
    .sync_o (pad_sync)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_sel && bus_wr && addr_ok && (32'(bsel) == b);

    pinbank_bank #(.NPINS(NPINS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_en    (hit),
      .grp      (grp),
      .wdata    (bus_wdata[NPINS-1:0]),
      .pin_sync (pad_sync[b*NPINS +: NPINS]),
      .rdata    (rd_bank[b]),
      .pad_out  (pad_out[b*NPINS +: NPINS]),
      .pad_oe   (pad_oe[b*NPINS +: NPINS]),
      .pad_own  (pad_own[b*NPINS +: NPINS]),
      .irq      (irq[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bus_sel && !bus_wr && addr_ok && (32'(bsel) == b)) begin
        bus_rdata[NPINS-1:0] = rd_bank[b];
      end
    end
  end

  // R4: a pad is never driven unless the GPIO function owns it
  a_r4_oe_needs_own: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pad_oe & ~pad_own) == '0);

  // R2: the unused top bits never carry data
  a_r2_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rdata[DATA_W-1:NPINS] == '0);
endmodule

// File: tb/pinbank_gpio_test.sv
module pinbank_gpio_test;
  localparam int NB  = 3;
  localparam int NP  = 30;
  localparam int TOT = NB * NP;
  localparam logic [31:0] VMASK = 32'h3FFF_FFFF;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_sel, bus_wr;
  logic [7:0]     bus_addr;
  logic [31:0]    bus_wdata, bus_rdata;
  logic [TOT-1:0] pad_in, pad_out, pad_oe, pad_own;
  logic [NB-1:0]  irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [NB][16];

  always #4 clk = ~clk;

  pinbank_gpio uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_own(pad_own),
    .irq(irq)
  );

  function automatic logic [7:0] adr(int g, int b);
    return 8'((g << 4) | (b << 2));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_now(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rchk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    @(negedge clk);
    rd_now(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cfg_g [6] = '{0, 2, 3, 4, 6, 8};
    int pins  [3] = '{0, 14, 29};
    logic [31:0] v, pat;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pad_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);

    // R3: reset state
    for (int b = 0; b < NB; b++) begin
      rchk("R3 dir reset", adr(0, b), VMASK);
      for (int i = 1; i < 6; i++) rchk("R3 cfg reset", adr(cfg_g[i], b), 32'h0);
      rchk("R3 flag reset", adr(5, b), 32'h0);
    end
    chk("R3 irq reset", 32'(irq), 32'h0);
    chk("R3 oe reset", 32'(|pad_oe), 32'h0);
    chk("R3 own reset", 32'(|pad_own), 32'h0);

    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2: distinct pattern in every bank/group, then read back all
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 6; i++) begin
        pat = 32'hC000_0000 | (32'h0ACE_1357 * 32'(b * 6 + i + 1));
        wr(adr(cfg_g[i], b), pat);
        shadow[b][cfg_g[i]] = pat & VMASK;
      end
    for (int i = 0; i < 6; i++) wr(adr(cfg_g[i], 3), 32'hFFFF_FFFF);
    wr(8'h01, 32'h0);
    wr(8'h83, 32'hFFFF_FFFF);
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 6; i++)
        rchk("R1 R2 readback", adr(cfg_g[i], b), shadow[b][cfg_g[i]]);
    rchk("R1 bank3 reads zero", adr(0, 3), 32'h0);
    rchk("R1 group1 reads zero", adr(1, 0), 32'h0);
    rchk("R1 group9 reads zero", adr(9, 1), 32'h0);
    rchk("R1 groupF reads zero", adr(15, 2), 32'h0);
    rchk("R1 misaligned reads zero", 8'h81, 32'h0);

    // R4: pad-side outputs
    for (int b = 0; b < NB; b++) begin
      chk("R4 pad_own", 32'(pad_own[b*NP +: NP]), shadow[b][6]);
      chk("R4 pad_oe", 32'(pad_oe[b*NP +: NP]), shadow[b][6] & ~shadow[b][0] & VMASK);
      chk("R4 pad_out", 32'(pad_out[b*NP +: NP]), shadow[b][8]);
    end

    // R5: input synchronizer latency
    @(negedge clk) pad_in = {30'h2AAA_5555, 30'h1234_5678, 30'h3C3C_0F0F};
    @(negedge clk);
    rd_now(adr(7, 0), v); chk("R5 din after one edge", v, 32'h0);
    @(negedge clk);
    rd_now(adr(7, 0), v); chk("R5 din after two edges", v, 32'h3C3C_0F0F);
    rchk("R5 din bank1", adr(7, 1), 32'h1234_5678);
    rchk("R5 din bank2", adr(7, 2), 32'h2AAA_5555);
    // R10: input data is read-only
    wr(adr(7, 0), 32'h0);
    rd_now(adr(7, 0), v); chk("R10 din unchanged by write", v, 32'h3C3C_0F0F);

    // quiet configuration for interrupt sweep
    for (int b = 0; b < NB; b++) begin
      wr(adr(0, b), VMASK); wr(adr(4, b), 0); wr(adr(6, b), 0);
      wr(adr(3, b), VMASK); wr(adr(2, b), VMASK);
    end
    @(negedge clk) pad_in = '0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < NB; b++) wr(adr(5, b), 0);
    chk("R9 irq quiet", 32'(irq), 32'h0);

    // R6 R7 R8 R9: every bank, edge and middle pins, all four trigger modes
    for (int b = 0; b < NB; b++)
      for (int pi = 0; pi < 3; pi++)
        for (int m = 0; m < 4; m++) begin
          logic kind, sns;
          logic [31:0] bit_m;
          kind  = m[1];
          sns   = m[0];
          bit_m = 32'h1 << pins[pi];
          @(negedge clk) pad_in[b*NP +: NP] = {NP{~sns}};
          wr(adr(3, b), {32{kind}} & VMASK);
          wr(adr(2, b), {32{sns}} & VMASK);
          wr(adr(4, b), bit_m);
          repeat (4) @(negedge clk);
          wr(adr(5, b), 0);
          rd_now(adr(5, b), v); chk("R8 flags cleared", v, 32'h0);
          chk("R9 irq idle", 32'(irq), 32'h0);

          @(negedge clk) pad_in[b*NP + pins[pi]] = sns;
          @(negedge clk);
          @(negedge clk);
          rd_now(adr(5, b), v); chk(kind ? "R6 flag not early" : "R7 flag not early", v, 32'h0);
          @(negedge clk);
          rd_now(adr(5, b), v); chk(kind ? "R6 flag set" : "R7 flag set", v, bit_m);
          chk("R9 irq raised", 32'(irq), 32'(1 << b));
          wr(adr(5, b), 32'hFFFF_FFFF);
          rd_now(adr(5, b), v); chk("R8 write one keeps", v, bit_m);

          if (kind) begin
            wr(adr(0, b), VMASK & ~bit_m);
            chk("R9 output pin masked", 32'(irq), 32'h0);
            wr(adr(0, b), VMASK);
            chk("R9 input pin restored", 32'(irq), 32'(1 << b));
            wr(adr(4, b), 0);
            chk("R9 mask off", 32'(irq), 32'h0);
            wr(adr(4, b), bit_m);
            wr(adr(5, b), 0);
            rd_now(adr(5, b), v); chk("R8 write zero clears", v, 32'h0);
            chk("R9 irq after clear", 32'(irq), 32'h0);
            @(negedge clk) pad_in[b*NP + pins[pi]] = ~sns;
            repeat (4) @(negedge clk);
            rd_now(adr(5, b), v); chk("R6 leaving edge ignored", v, 32'h0);
          end else begin
            wr(adr(5, b), 0);
            rd_now(adr(5, b), v); chk("R7 level keeps flag", v, bit_m);
            @(negedge clk) pad_in[b*NP + pins[pi]] = ~sns;
            repeat (4) @(negedge clk);
            wr(adr(5, b), 0);
            rd_now(adr(5, b), v); chk("R7 clear after level gone", v, 32'h0);
          end
          wr(adr(4, b), 0);
        end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule